// File: doc/BRIEF.md
# Five-Master Shared Bus Arbiter with Transaction Watchdog

This block decides which of five masters owns a shared bus: the CPU, two graphics channels, a core I/O bus and an expansion bus. It grants ownership to one master at a time, registered, and keeps the grant until that master signals completion. Software configures it through a write-only control word. The word holds a mask that shuts individual masters out, a field that names one master as preferred, and a watchdog limit counted in clocks.

The preferred master owns every reserved slot. A reserved slot is the arbitration that follows any grant that did not itself go to the preferred master through its reservation. All other arbitrations rotate round-robin over the masters that are requesting and not shut out. Each grant loads the watchdog. If the transaction has not completed when the watchdog runs out, the grant is torn down and a sticky error flag is raised. The flag stays set until reset or an explicit clear pulse. Two summary outputs tell software whether any preference is in force and whether any master is shut out.

Top module: `bus_arb5`

## Requirements
- R1: Master index 0 is the CPU, 1 graphics channel 0, 2 graphics channel 1, 3 the core bus and 4 the expansion bus. `grant_o` is one-hot in that bit order. An arbitration happens only while no grant is held. If an eligible master requests in such a cycle, its grant bit rises at the next clock edge and stays constant until the transaction ends.
- R2: After reset `grant_o` is 0, the deny bits of masters 1 to 4 are 1, every preference bit is 0, `tout_err_o` is 0, `any_deny_o` is 1 and `any_pref_o` is 0.
- R3: A master whose deny bit is 1 is never granted. Bit 0 of `cfg_deny_i` has no effect: the CPU can always be granted.
- R4: A control write (`cfg_we_i` high) stores the deny mask and the watchdog limit. Of the preference bits it keeps only the lowest-indexed set bit.
- R5: A slot is reserved unless the previous grant went to the preferred master in a reserved slot; the first slot after reset is reserved. In a reserved slot the preferred master is granted when it is requesting and not denied.
- R6: Any arbitration not taken by the preferred master picks the first eligible requester in increasing cyclic index order, starting after the previous round-robin winner. The pointer starts at index 0 after reset. Grants made through the reservation leave the pointer unchanged.
- R7: `any_pref_o` is 1 when any stored preference bit is 1. `any_deny_o` is 1 when any stored deny bit is 1.
- R8: Each grant loads the watchdog with the stored limit L (13 bits). If `done_i` never arrives, the grant stays high for L+1 cycles and then drops, and `tout_err_o` rises at the same edge.
- R9: `tout_err_o` is sticky. Only reset or a one-cycle `err_clr_i` clears it, and an expiry in the same cycle wins over the clear.
- R10: `done_i` high while a grant is held releases the grant at the next edge and leaves `tout_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_pref_i | input | 5 | Preference bits, one per master |
| cfg_deny_i | input | 5 | Deny bits, one per master (bit 0 ignored) |
| cfg_tout_i | input | 13 | Watchdog limit in clocks |
| req_i | input | 5 | Bus requests, one per master |
| done_i | input | 1 | Current transaction complete |
| err_clr_i | input | 1 | Clears the sticky timeout flag |
| grant_o | output | 5 | One-hot bus grant |
| any_pref_o | output | 1 | Some preference bit is set |
| any_deny_o | output | 1 | Some deny bit is set |
| tout_err_o | output | 1 | Sticky bus-error timeout flag |

## Verification
With every master requesting and no mask, the grant order must walk all five indices, which exposes a wrong rotation start or direction. Holes in the deny mask show whether denied masters are skipped and whether the CPU deny bit is ignored. Two preference bits written together, with all masters requesting, show whether the lowest index is kept and whether reserved and round-robin slots alternate. The same reservation with the preferred master idle or denied shows that its slot falls back to rotation. Limits of 5 and 0 with no completion pin down the exact grant length at expiry, and a later normal transaction and a clear pulse separate sticky behaviour from self-clearing.

// File: rtl/arb5_pkg.sv
package arb5_pkg;
  localparam int unsigned N_MST  = 5;
  localparam int unsigned TOUT_W = 13;
  localparam int unsigned MST_CPU  = 0;
  localparam int unsigned MST_GFX0 = 1;
  localparam int unsigned MST_GFX1 = 2;
  localparam int unsigned MST_CORE = 3;
  localparam int unsigned MST_EXP  = 4;
endpackage

// File: rtl/arb5_cfg.sv
module arb5_cfg #(
  parameter int unsigned N    = arb5_pkg::N_MST,
  parameter int unsigned TW   = arb5_pkg::TOUT_W,
  parameter logic [TW-1:0] TRST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [N-1:0]  pref_i,
  input  logic [N-1:0]  deny_i,
  input  logic [TW-1:0] tout_i,
  output logic [N-1:0]  pref_o,
  output logic [N-1:0]  deny_o,
  output logic [TW-1:0] tout_o,
  output logic          any_pref_o,
  output logic          any_deny_o
);
  // CPU (index 0) cannot be denied
  localparam logic [N-1:0] DENY_MASK = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] pref_low;
  assign pref_low = pref_i & (~pref_i + N'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pref_o <= '0;
      deny_o <= DENY_MASK;
      tout_o <= TRST;
    end else if (we_i) begin
      pref_o <= pref_low;
      deny_o <= deny_i & DENY_MASK;
      tout_o <= tout_i;
    end
  end

  assign any_pref_o = |pref_o;
  assign any_deny_o = |deny_o;

  AST_PREF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pref_o)); // R4
  AST_CPU_NODENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (deny_o[0] == 1'b0)); // R3
endmodule

// File: rtl/arb5_pick.sv
module arb5_pick #(
  parameter int unsigned N  = arb5_pkg::N_MST,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  deny_i,
  input  logic [N-1:0]  pref_i,
  input  logic          pref_slot_i,
  input  logic [IW-1:0] last_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  gnt_o,
  output logic          pref_win_o
);
  logic [N-1:0]  elig;
  logic          rr_found;
  logic [IW-1:0] rr_idx;
  logic [IW-1:0] pref_idx;

  assign elig = req_i & ~deny_i;

  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int j;
      j = (int'(last_i) + k) % int'(N);
      if (!rr_found && elig[j]) begin
        rr_found = 1'b1;
        rr_idx   = IW'(j);
      end
    end
  end

  always_comb begin
    pref_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (pref_i[i]) pref_idx = IW'(i);
    end
  end

  always_comb begin
    pref_win_o = pref_slot_i && |(pref_i & elig);
    valid_o    = |elig;
    idx_o      = pref_win_o ? pref_idx : rr_idx;
    gnt_o      = '0;
    if (valid_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/arb5_tout.sv
module arb5_tout #(
  parameter int unsigned TW = arb5_pkg::TOUT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [TW-1:0] limit_i,
  input  logic          clr_i,
  output logic          expire_o,
  output logic          err_o
);
  logic [TW-1:0] cnt_q;

  assign expire_o = busy_i && !done_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= limit_i;
    end else if (busy_i && !done_i && cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (expire_o) err_o <= 1'b1;
    else if (clr_i)    err_o <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o); // R9
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(limit_i))); // R8
endmodule

// File: rtl/bus_arb5.sv
module bus_arb5 #(
  parameter int unsigned N_MST  = arb5_pkg::N_MST,
  parameter int unsigned TOUT_W = arb5_pkg::TOUT_W,
  parameter logic [TOUT_W-1:0] TOUT_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [N_MST-1:0]  cfg_pref_i,
  input  logic [N_MST-1:0]  cfg_deny_i,
  input  logic [TOUT_W-1:0] cfg_tout_i,
  input  logic [N_MST-1:0]  req_i,
  input  logic              done_i,
  input  logic              err_clr_i,
  output logic [N_MST-1:0]  grant_o,
  output logic              any_pref_o,
  output logic              any_deny_o,
  output logic              tout_err_o
);
  localparam int unsigned IW = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic [N_MST-1:0]  pref_q, deny_q, pick_gnt, grant_q;
  logic [TOUT_W-1:0] tout_q;
  logic [IW-1:0]     last_q, pick_idx;
  logic              pref_slot_q, pick_valid, pick_pref_win;
  logic              busy, issue, expire;

  arb5_cfg #(.N(N_MST), .TW(TOUT_W), .TRST(TOUT_RST)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .pref_i(cfg_pref_i), .deny_i(cfg_deny_i), .tout_i(cfg_tout_i),
    .pref_o(pref_q), .deny_o(deny_q), .tout_o(tout_q),
    .any_pref_o(any_pref_o), .any_deny_o(any_deny_o)
  );

  arb5_pick #(.N(N_MST), .IW(IW)) u_pick (
    .req_i(req_i), .deny_i(deny_q), .pref_i(pref_q),
    .pref_slot_i(pref_slot_q), .last_i(last_q),
    .valid_o(pick_valid), .idx_o(pick_idx), .gnt_o(pick_gnt),
    .pref_win_o(pick_pref_win)
  );

  assign busy  = |grant_q;
  assign issue = !busy && pick_valid;

  arb5_tout #(.TW(TOUT_W)) u_tout (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(issue), .busy_i(busy),
    .done_i(done_i), .limit_i(tout_q), .clr_i(err_clr_i),
    .expire_o(expire), .err_o(tout_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q     <= '0;
      last_q      <= '0;
      pref_slot_q <= 1'b1;
    end else if (issue) begin
      grant_q     <= pick_gnt;
      pref_slot_q <= !pick_pref_win;
      if (!pick_pref_win) last_q <= pick_idx;
    end else if (busy && (done_i || expire)) begin
      grant_q <= '0;
    end
  end

  assign grant_o = grant_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q)); // R1
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i && !expire) |=> $stable(grant_q)); // R1
  AST_NO_DENIED_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> ((grant_q & $past(deny_q)) == '0)); // R3
  AST_PREF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && pref_slot_q && |(pref_q & req_i & ~deny_q)) |=> (grant_q == $past(pref_q))); // R5
  AST_EXPIRE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (grant_q == '0 && tout_err_o)); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i) |=> (grant_q == '0)); // R10
endmodule

// File: tb/bus_arb5_tb_top.sv
module bus_arb5_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_pref = '0, cfg_deny = '0, req = '0;
  logic [12:0] cfg_tout = '0;
  logic        done = 1'b0, err_clr = 1'b0;
  logic [4:0]  grant;
  logic        any_pref, any_deny, tout_err;

  int n_chk = 0, n_fail = 0;
  bit resp_en = 1'b1;
  bit finished = 1'b0;
  int exp_q[$];
  string tag_q[$];
  logic [4:0] prev_gnt = '0;

  always #5 clk = ~clk;

  bus_arb5 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_pref_i(cfg_pref),
    .cfg_deny_i(cfg_deny), .cfg_tout_i(cfg_tout), .req_i(req), .done_i(done),
    .err_clr_i(err_clr), .grant_o(grant), .any_pref_o(any_pref),
    .any_deny_o(any_deny), .tout_err_o(tout_err)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gidx(logic [4:0] g);
    for (int i = 0; i < 5; i++) if (g[i]) return i;
    return -1;
  endfunction

  // responder: completes a transaction in its first grant cycle
  always @(negedge clk) done <= resp_en && (grant != '0);

  // monitor: compares each new grant against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (grant != '0 && prev_gnt == '0) begin
        chk($onehot(grant), "R1", int'(grant), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", gidx(grant), -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(gidx(grant) == e, t, gidx(grant), e);
        end
      end
      prev_gnt = grant;
    end
  end

  task automatic push(int idx, string tag);
    exp_q.push_back(idx);
    tag_q.push_back(tag);
  endtask

  task automatic cfg_write(logic [4:0] p, logic [4:0] d, logic [12:0] t);
    @(negedge clk);
    cfg_pref = p; cfg_deny = d; cfg_tout = t; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_seq(logic [4:0] r);
    req = r;
    wait (exp_q.size() == 0);
    req = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk(grant == '0, "R2", int'(grant), 0);
    chk(tout_err == 1'b0, "R2", int'(tout_err), 0);
    chk(any_deny == 1'b1, "R2", int'(any_deny), 1);
    chk(any_pref == 1'b0, "R2", int'(any_pref), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset mask: only the CPU is eligible
    push(0, "R2"); push(0, "R2"); push(0, "R3");
    run_seq(5'b11111);

    // no mask: full rotation
    cfg_write(5'b00000, 5'b00000, 13'd20);
    chk(any_deny == 1'b0, "R7", int'(any_deny), 0);
    push(1, "R6"); push(2, "R6"); push(3, "R6"); push(4, "R6"); push(0, "R6");
    run_seq(5'b11111);
    chk(tout_err == 1'b0, "R10", int'(tout_err), 0);

    // graphics channel 1 denied
    cfg_write(5'b00000, 5'b00100, 13'd20);
    push(1, "R3"); push(3, "R3"); push(4, "R3"); push(0, "R6"); push(1, "R6");
    run_seq(5'b11111);

    // two preference bits: lowest (index 2) kept
    cfg_write(5'b01100, 5'b00000, 13'd20);
    chk(any_pref == 1'b1, "R7", int'(any_pref), 1);
    push(2, "R4"); push(2, "R6"); push(2, "R5"); push(3, "R6");
    push(2, "R5"); push(4, "R6"); push(2, "R5"); push(0, "R6");
    run_seq(5'b11111);

    // preferred master idle: reserved slot falls back to rotation
    push(1, "R5"); push(4, "R5"); push(0, "R6"); push(1, "R6");
    run_seq(5'b10011);

    // preferred master denied
    cfg_write(5'b00100, 5'b00100, 13'd20);
    push(3, "R3"); push(4, "R3"); push(0, "R3"); push(1, "R3");
    run_seq(5'b11111);

    // all deny bits written, CPU still served
    cfg_write(5'b00000, 5'b11111, 13'd20);
    chk(any_deny == 1'b1, "R7", int'(any_deny), 1);
    chk(any_pref == 1'b0, "R7", int'(any_pref), 0);
    push(0, "R3"); push(0, "R3");
    run_seq(5'b11111);

    // watchdog limit 5, no completion
    cfg_write(5'b00000, 5'b00000, 13'd5);
    resp_en = 1'b0;
    push(1, "R8");
    req = 5'b00010;
    wait (exp_q.size() == 0);
    req = '0;
    len = 1;
    @(negedge clk);
    while (grant != '0) begin
      len++;
      @(negedge clk);
    end
    chk(len == 6, "R8", len, 6);
    chk(tout_err == 1'b1, "R8", int'(tout_err), 1);
    repeat (3) @(negedge clk);
    chk(tout_err == 1'b1, "R9", int'(tout_err), 1);

    // normal transaction does not clear the flag
    resp_en = 1'b1;
    push(0, "R10");
    run_seq(5'b00001);
    chk(tout_err == 1'b1, "R9", int'(tout_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(tout_err == 1'b0, "R9", int'(tout_err), 0);

    // limit 0: grant lasts one cycle
    cfg_write(5'b00000, 5'b00000, 13'd0);
    resp_en = 1'b0;
    push(2, "R8");
    req = 5'b00100;
    wait (exp_q.size() == 0);
    req = '0;
    len = 1;
    @(negedge clk);
    while (grant != '0) begin
      len++;
      @(negedge clk);
    end
    chk(len == 1, "R8", len, 1);
    chk(tout_err == 1'b1, "R8", int'(tout_err), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(tout_err == 1'b0, "R9", int'(tout_err), 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule